// File: doc/BRIEF.md
# Prioritized Fast/Normal Interrupt Vector Controller

This block gathers interrupt events from many peripherals into sticky pending flags, one per source. A per-source class bit sends each flag either to the fast request line or to the normal request line, and a per-source enable bit can mask it. For each of the two classes, a priority resolver picks the lowest-numbered enabled pending source and loads that source's number plus one into the class's 8-bit vector register. A value of zero means that nothing in the class is pending.

A processor reaches the block over a simple register bus. Read data comes back one cycle after the read strobe and is flagged by `reg_rvalid`. Reading a vector register returns its contents and clears it in the same edge, so a second read in the same service pass returns zero. On the following clock the register reloads from whatever is still pending. Hardware never clears a pending flag. Software clears a flag by writing a 1 to its bit in the flag register. A source that is left uncleared keeps its request line asserted, so it is requested again as soon as its handler returns.

All ports are plain control and status signals. There is no streaming interface and no back-pressure. The bus strobe is accepted on every cycle in which `reg_en` is high.

Top module: `intr_vector_ctrl`

## Requirements
- R1: A high `src_evt[i]` at a clock edge sets pending flag i. The flag stays set until software clears it, and hardware never clears it.
- R2: A write to address 2 clears every flag whose bit in `reg_wdata` is 1. If an event for the same source arrives in the same cycle as the clear, the event wins and the flag stays set.
- R3: A source whose enable bit (address 3, bit i, 1 = enabled, reset 0) is 0 takes no part in priority resolution and does not drive either request line. Its pending flag is kept.
- R4: Class bit i (address 4, 1 = fast class, 0 = normal class, reset 0) routes source i. `fiq_o` serves the fast class and `irq_o` serves the normal class.
- R5: The fast vector (address 0) and the normal vector (address 1) hold the index of the lowest-numbered enabled pending source in their class plus one, in bits 7:0. They hold 0 when no such source exists. With 32 sources the largest value is 32.
- R6: A read of a vector register returns its value and clears it at the same edge. A read in the very next cycle returns 0. One cycle after a read that is not followed by another read, the register holds the current winner again.
- R7: The request outputs are registered and active high. A request goes high one clock after an enabled flag of its class sets. It stays high while any enabled flag of its class remains set, including after its vector has been read.
- R8: Read data appears on `reg_rdata` one cycle after the strobe, with `reg_rvalid` high for that one cycle. Addresses 2, 3 and 4 read back the flags, the enables and the class bits. Unused addresses read 0.
- R9: While `rst_n` is low, all flags, enables, class bits, vectors and request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_evt | input | NUM_SRC | Per-source event inputs; a high level at an edge sets the flag |
| reg_en | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one cycle after the strobe |
| reg_rvalid | output | 1 | High in the cycle that `reg_rdata` is valid |
| fiq_o | output | 1 | Fast-class request line |
| irq_o | output | 1 | Normal-class request line |

## Verification
The hardest case to reach from the ports is an event that lands in the exact cycle a clear write for the same source takes effect. The bench handles it with one task that raises `src_evt` and the bus write together at the same falling edge, then reads the flag register back. A second hard case is two vector reads issued on adjacent cycles, before the register has had a clock to reload. A dedicated read task issues the two strobes on consecutive edges and expects the value and then zero. A later read, after a one-cycle gap, must show the reloaded winner.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  // register addresses; the normal vector must sit right after the fast one
  localparam int ADDR_VEC_FAST = 0;
  localparam int ADDR_VEC_NORM = 1;
  localparam int ADDR_FLAGS    = 2;
  localparam int ADDR_ENABLE   = 3;
  localparam int ADDR_CLASS    = 4;

  localparam int NUM_CLS  = 2;
  localparam int CLS_FAST = 0;
  localparam int CLS_NORM = 1;
endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_q
);
  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_i) | set_i;
  end
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 8
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [VEC_W-1:0]   vec_o
);
  // lowest index wins; result is index + 1, zero when idle
  always_comb begin
    vec_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) vec_o = VEC_W'(i + 1);
    end
  end
endmodule

// File: rtl/ivc_vec_reg.sv
module ivc_vec_reg #(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sel_i,
  input  logic [VEC_W-1:0]   win_i,
  input  logic               rd_clr_i,
  output logic [VEC_W-1:0]   vec_q,
  output logic               req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      req_q <= 1'b0;
    end else begin
      vec_q <= rd_clr_i ? '0 : win_i;
      req_q <= |sel_i;
    end
  end
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               reg_en,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  output logic               fiq_o,
  output logic               irq_o
);
  localparam int SRC_BITS = (NUM_SRC < DATA_W) ? NUM_SRC : DATA_W;

  logic                rd_stb, wr_stb;
  logic [NUM_SRC-1:0]  wdata_src;
  logic [NUM_SRC-1:0]  flag_q, en_q, map_q, pend, clr;
  logic [VEC_W-1:0]    vec_q [NUM_CLS];
  logic [NUM_CLS-1:0]  req_q;
  logic [NUM_CLS-1:0]  rd_vec;
  logic [VEC_W-1:0]    vec_fast, vec_norm;
  logic [DATA_W-1:0]   rd_mux, rdata_q;
  logic                rvalid_q;

  assign rd_stb    = reg_en && !reg_wr;
  assign wr_stb    = reg_en &&  reg_wr;
  assign wdata_src = NUM_SRC'(reg_wdata[SRC_BITS-1:0]);
  assign clr       = (wr_stb && reg_addr == ADDR_W'(ADDR_FLAGS)) ? wdata_src : '0;

  // enable and class registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      map_q <= '0;
    end else if (wr_stb) begin
      if (reg_addr == ADDR_W'(ADDR_ENABLE)) en_q  <= wdata_src;
      if (reg_addr == ADDR_W'(ADDR_CLASS))  map_q <= wdata_src;
    end
  end

  ivc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_evt),
    .clr_i  (clr),
    .flag_q (flag_q)
  );

  assign pend = flag_q & en_q;

  // one resolver and vector register per class
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    logic [NUM_SRC-1:0] sel;
    logic [VEC_W-1:0]   win;
    assign sel       = pend & ((c == CLS_FAST) ? map_q : ~map_q);
    assign rd_vec[c] = rd_stb && (reg_addr == ADDR_W'(ADDR_VEC_FAST + c));

    ivc_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_enc (
      .req_i (sel),
      .vec_o (win)
    );

    ivc_vec_reg #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_vec (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (sel),
      .win_i    (win),
      .rd_clr_i (rd_vec[c]),
      .vec_q    (vec_q[c]),
      .req_q    (req_q[c])
    );
  end

  assign vec_fast = vec_q[CLS_FAST];
  assign vec_norm = vec_q[CLS_NORM];
  assign fiq_o    = req_q[CLS_FAST];
  assign irq_o    = req_q[CLS_NORM];

  // read mux, registered
  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADDR_VEC_FAST))     rd_mux = DATA_W'(vec_fast);
    else if (reg_addr == ADDR_W'(ADDR_VEC_NORM)) rd_mux = DATA_W'(vec_norm);
    else if (reg_addr == ADDR_W'(ADDR_FLAGS))    rd_mux = DATA_W'(flag_q);
    else if (reg_addr == ADDR_W'(ADDR_ENABLE))   rd_mux = DATA_W'(en_q);
    else if (reg_addr == ADDR_W'(ADDR_CLASS))    rd_mux = DATA_W'(map_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_stb;
      if (rd_stb) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int VEC_W   = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_en,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [NUM_SRC-1:0] src_evt,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] map_q,
  input logic [VEC_W-1:0]   vec_fast,
  input logic [VEC_W-1:0]   vec_norm,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               reg_rvalid,
  input logic               fiq_o,
  input logic               irq_o
);
  logic rd_fast, rd_norm, clr_wr;
  assign rd_fast = reg_en && !reg_wr && reg_addr == ADDR_W'(ADDR_VEC_FAST);
  assign rd_norm = reg_en && !reg_wr && reg_addr == ADDR_W'(ADDR_VEC_NORM);
  assign clr_wr  = reg_en &&  reg_wr && reg_addr == ADDR_W'(ADDR_FLAGS);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flags & $past(flags)) == $past(flags))); // R1
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((flags & $past(src_evt)) == $past(src_evt))); // R2
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags & en_q)) |=> (!fiq_o && !irq_o)); // R3
  AST_FAST_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & en_q & map_q)) |=> fiq_o); // R7
  AST_NORM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & en_q & ~map_q)) |=> irq_o); // R7
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_fast <= VEC_W'(NUM_SRC)) && (vec_norm <= VEC_W'(NUM_SRC))); // R5
  AST_FAST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fast |=> (vec_fast == '0 && reg_rdata == DATA_W'($past(vec_fast)))); // R6
  AST_NORM_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_norm |=> (vec_norm == '0 && reg_rdata == DATA_W'($past(vec_norm)))); // R6
  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_wr) |=> reg_rvalid); // R8
endmodule

bind intr_vector_ctrl ivc_checker #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_ivc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_en     (reg_en),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .src_evt    (src_evt),
  .flags      (flag_q),
  .en_q       (en_q),
  .map_q      (map_q),
  .vec_fast   (vec_fast),
  .vec_norm   (vec_norm),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .fiq_o      (fiq_o),
  .irq_o      (irq_o)
);

// File: tb/tb_intr_vector_ctrl.sv
module tb_intr_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_evt = '0;
  logic            reg_en = 1'b0, reg_wr = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            reg_rvalid, fiq_o, irq_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .fiq_o(fiq_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    chk("R8 rvalid", {31'd0, reg_rvalid}, 32'd1);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    src_evt = m;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 fiq", {31'd0, fiq_o}, 0);
    chk("R9 irq", {31'd0, irq_o}, 0);
    do_read(0, d); chk("R9 fast vec", d, 0);
    do_read(2, d); chk("R9 flags", d, 0);
    do_read(3, d); chk("R9 enables", d, 0);
    do_read(4, d); chk("R9 class", d, 0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    do_write(3, 32'hFFFF_FFFF);
    do_write(4, 32'h0000_00F0);
    do_read(3, d); chk("R8 enable readback", d, 32'hFFFF_FFFF);
    do_read(4, d); chk("R8 class readback", d, 32'h0000_00F0);
    do_read(7, d); chk("R8 unused address", d, 0);
    pulse((32'd1 << 5) | (32'd1 << 9));
    wait_cyc(2);
    chk("R4 fiq", {31'd0, fiq_o}, 1);
    chk("R4 irq", {31'd0, irq_o}, 1);
    do_read(0, d); chk("R5 fast vec", d, 6);
    do_read(1, d); chk("R5 normal vec", d, 10);
  endtask

  task automatic t_priority_and_clear_on_read();
    logic [31:0] d;
    pulse(32'd1 << 4);
    wait_cyc(2);
    do_read(0, d); chk("R5 lowest wins", d, 5);
    do_read(0, d); chk("R6 back-to-back read", d, 0);
    wait_cyc(1);
    do_read(0, d); chk("R6 reload after read", d, 5);
    do_read(2, d); chk("R1 flags kept", d, (32'd1 << 4) | (32'd1 << 5) | (32'd1 << 9));
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    do_write(2, 32'd1 << 4);
    wait_cyc(2);
    do_read(0, d); chk("R2 next winner", d, 6);
    do_write(2, 32'd1 << 5);
    wait_cyc(2);
    chk("R2 fiq drops", {31'd0, fiq_o}, 0);
    do_read(2, d); chk("R2 flags after clear", d, 32'd1 << 9);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    src_evt = 32'd1 << 3;
    reg_en = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'd1 << 3;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0; src_evt = '0;
    do_read(2, d); chk("R2 event beats clear", d, (32'd1 << 3) | (32'd1 << 9));
    do_write(2, 32'd1 << 3);
    wait_cyc(1);
    do_read(2, d); chk("R2 clear alone", d, 32'd1 << 9);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    do_write(3, ~(32'd1 << 9));
    wait_cyc(2);
    chk("R3 masked irq low", {31'd0, irq_o}, 0);
    do_read(1, d); chk("R3 masked vec", d, 0);
    do_read(2, d); chk("R3 flag kept", d, 32'd1 << 9);
    pulse(32'd1 << 12);
    wait_cyc(2);
    do_read(1, d); chk("R3 masked skipped", d, 13);
    do_write(3, 32'hFFFF_FFFF);
    wait_cyc(2);
    do_read(1, d); chk("R3 unmasked wins", d, 10);
    do_write(2, 32'hFFFF_FFFF);
    wait_cyc(2);
    chk("R1 all cleared irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_req_timing();
    logic [31:0] d;
    src_evt = 32'd1 << 6;
    @(posedge clk); #1; src_evt = '0;
    chk("R7 not before flag", {31'd0, fiq_o}, 0);
    @(posedge clk); #1;
    chk("R7 one clock after flag", {31'd0, fiq_o}, 1);
    @(negedge clk);
    do_read(0, d); chk("R7 vector", d, 7);
    wait_cyc(2);
    chk("R7 retrigger uncleared", {31'd0, fiq_o}, 1);
  endtask

  task automatic t_remap_and_top();
    logic [31:0] d;
    do_write(4, 32'h8000_0000);
    wait_cyc(2);
    chk("R4 remap fiq", {31'd0, fiq_o}, 0);
    chk("R4 remap irq", {31'd0, irq_o}, 1);
    do_read(1, d); chk("R4 remap vec", d, 7);
    pulse(32'd1 << 31);
    wait_cyc(2);
    do_read(0, d); chk("R5 highest source", d, 32);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_priority_and_clear_on_read();
    t_w1c();
    t_collision();
    t_mask();
    t_req_timing();
    t_remap_and_top();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule